// File: doc/BRIEF.md
# Dual-Mode Host Register Interface

This block lets an external processor read and write a small bank of configuration and status registers over a 16-bit parallel port. A mode input selects between two strobe styles on the same pins. With mode low, the port uses separate read and write strobes, both qualified by an active-low chip enable. With mode high, the read pin becomes a direction line: high means read and low means write. In that mode the access is framed by the chip enable alone. The core-level port presents the bidirectional bus as an input half, an output half and an output enable for the pad. The pad pulls the mode pin low when it is unconnected, which selects the separate-strobe style.

Reads are combinational from the pins to the output half of the bus. Writes are synchronised into the core clock and committed exactly once, at the end of each write access. The address and data are captured while the access is still open.

An interrupt output pulses for a programmable number of core cycles whenever the selected channel reports new data. A new event restarts the count. The configuration registers drive a flat output vector for the datapath, which lies outside this block. The interface has no stream traffic, so all pins are plain level signals with no valid/ready handshake and no back-pressure.

Top module: `hostif_top`

## Requirements
- R1: After reset, every configuration register reads 0, the pulse-length register reads 1, the channel-select register reads 0, `irq_o` is low and `data_oe_o` is low.
- R2: With `mode_i` low, `data_oe_o` is high and `data_o` carries the addressed register exactly while `cs_ni` and `rd_ni` are both low.
- R3: With `mode_i` high, `data_oe_o` is high and `data_o` carries the addressed register exactly while `cs_ni` is low and `rd_ni` (direction) is high.
- R4: While `cs_ni` is high, `data_oe_o` stays low whatever the strobes do.
- R5: With `mode_i` low, a write access is the time during which `cs_ni` and `wr_ni` are both low. It writes the address and data present during the access once. The result is visible on the third rising clock edge after the access ends.
- R6: With `mode_i` high, a write access is the time during which `cs_ni` is low and `rd_ni` is low. It commits once with the same latency as R5.
- R7: Register map:
  - Addresses 0 to 3 hold configuration registers, 16 bits each.
  - Address 4 holds the pulse length in bits 7:0.
  - Address 5 holds the channel select in bits 1:0.
  - Address 6 reads `status_i` and ignores writes.
  - Every other address reads 0 and ignores writes.
- R8: A one-cycle high on `new_data_i[sel]` at a clock edge makes `irq_o` high for exactly `len` cycles, starting at that edge. Events on unselected channels have no effect.
- R9: An event on the selected channel that arrives while a pulse is running restarts the count at `len`.
- R10: A pulse length of 0 suppresses the interrupt entirely.
- R11: When an event and a write commit fall on the same clock edge, the event uses the length and select values from before that write.
- R12: With `mode_i` high, `wr_ni` has no effect: toggling it during an access writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Strobe style: 0 = separate strobes, 1 = direction line |
| cs_ni | input | 1 | Chip enable, active low |
| rd_ni | input | 1 | Read strobe (mode 0) or direction, 1 = read (mode 1) |
| wr_ni | input | 1 | Write strobe, active low (mode 0 only) |
| addr_i | input | 4 | Register address |
| data_i | input | 16 | Bus input half (write data) |
| data_o | output | 16 | Bus output half (read data, 0 when not driving) |
| data_oe_o | output | 1 | Pad output enable for the bus |
| status_i | input | 16 | Read-only status word |
| new_data_i | input | 4 | Per-channel new-data event, one cycle wide |
| irq_o | output | 1 | Interrupt pulse |
| cfg_o | output | 64 | Configuration registers 0 to 3, register k in bits 16k+15:16k |

## Verification
A write commit to the pulse-length or channel-select register can fall on the same clock edge as a new-data event. That collision decides which settings the pulse uses. The bench provokes it by timing the event to coincide with the third edge after a write access ends. Its cycle-by-cycle model updates the interrupt counter from the pre-edge register values before it applies the pending write, and `irq_o` is compared against that model on every clock. The bench also holds a read access open while toggling the unused write strobe in direction mode, to show that a read and a stray strobe in the same access never commit.

// File: rtl/hostif_pkg.sv
package hostif_pkg;
  localparam int DW = 16;

  typedef enum logic {
    STROBE_SPLIT = 1'b0,
    STROBE_RW    = 1'b1
  } strobe_mode_e;
endpackage

// File: rtl/hostif_sync.sv
module hostif_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[i] <= RST_VAL;
        else         stg[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[i] <= RST_VAL;
        else         stg[i] <= stg[i-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hostif_access.sv
module hostif_access
  import hostif_pkg::*;
#(
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          rd_en_o,
  output logic          commit_o,
  output logic [AW-1:0] commit_addr_o,
  output logic [DW-1:0] commit_data_o
);
  localparam int PW = AW + DW;

  strobe_mode_e md;
  logic         wacc_n;
  logic         wacc_s;
  logic         wacc_d;
  logic [PW-1:0] pay_s;
  logic [PW-1:0] pay_hold;

  assign md = strobe_mode_e'(mode_i);

  // Pin-level access qualification.
  always_comb begin
    if (md == STROBE_RW) begin
      wacc_n  = cs_ni | rd_ni;
      rd_en_o = !cs_ni && rd_ni;
    end else begin
      wacc_n  = cs_ni | wr_ni;
      rd_en_o = !cs_ni && !rd_ni;
    end
  end

  hostif_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_wacc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wacc_n),
    .q_o   (wacc_s)
  );

  hostif_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_sync_pay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({addr_i, data_i}),
    .q_o   (pay_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wacc_d   <= 1'b1;
      pay_hold <= '0;
    end else begin
      wacc_d <= wacc_s;
      if (!wacc_s) pay_hold <= pay_s;
    end
  end

  assign commit_o      = wacc_s && !wacc_d;
  assign commit_addr_o = pay_hold[PW-1:DW];
  assign commit_data_o = pay_hold[DW-1:0];

  AST_ONE_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o); // R5
  AST_COMMIT_AFTER_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(!wacc_s)); // R6
endmodule

// File: rtl/hostif_regbank.sv
module hostif_regbank
  import hostif_pkg::*;
#(
  parameter int NCFG = 4,
  parameter int AW   = 4,
  parameter int LENW = 8,
  parameter int CHW  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [AW-1:0]     commit_addr_i,
  input  logic [DW-1:0]     commit_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  input  logic [DW-1:0]     status_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NCFG*DW-1:0] cfg_o,
  output logic [LENW-1:0]   len_o,
  output logic [CHW-1:0]    sel_o
);
  localparam int ADDR_LEN  = NCFG;
  localparam int ADDR_SEL  = NCFG + 1;
  localparam int ADDR_STAT = NCFG + 2;

  logic [DW-1:0] cfg_q [NCFG];

  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cfg_q[k] <= '0;
      else if (commit_i && commit_addr_i == AW'(k))
        cfg_q[k] <= commit_data_i;
    end
    assign cfg_o[k*DW +: DW] = cfg_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_o <= LENW'(1);
      sel_o <= '0;
    end else if (commit_i) begin
      if (commit_addr_i == AW'(ADDR_LEN)) len_o <= commit_data_i[LENW-1:0];
      if (commit_addr_i == AW'(ADDR_SEL)) sel_o <= commit_data_i[CHW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NCFG; k++)
      if (rd_addr_i == AW'(k)) rdata_o = cfg_q[k];
    if (rd_addr_i == AW'(ADDR_LEN))  rdata_o = DW'(len_o);
    if (rd_addr_i == AW'(ADDR_SEL))  rdata_o = DW'(sel_o);
    if (rd_addr_i == AW'(ADDR_STAT)) rdata_o = status_i;
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(cfg_o)); // R7
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(len_o) && $stable(sel_o))); // R7
endmodule

// File: rtl/hostif_irq.sv
module hostif_irq #(
  parameter int NCH  = 4,
  parameter int CHW  = 2,
  parameter int LENW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCH-1:0]  new_data_i,
  input  logic [CHW-1:0]  sel_i,
  input  logic [LENW-1:0] len_i,
  output logic            irq_o
);
  logic [LENW-1:0] cnt_q;
  logic            evt;

  assign evt = new_data_i[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (evt)          cnt_q <= len_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign irq_o = (cnt_q != '0);

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && len_i != '0) |=> irq_o); // R8
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9
  AST_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && len_i == '0) |=> !irq_o); // R10
endmodule

// File: rtl/hostif_top.sv
module hostif_top
  import hostif_pkg::*;
#(
  parameter int NCFG        = 4,
  parameter int AW          = 4,
  parameter int LENW        = 8,
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CHW        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_i,
  input  logic                 cs_ni,
  input  logic                 rd_ni,
  input  logic                 wr_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        data_i,
  output logic [DW-1:0]        data_o,
  output logic                 data_oe_o,
  input  logic [DW-1:0]        status_i,
  input  logic [NCH-1:0]       new_data_i,
  output logic                 irq_o,
  output logic [NCFG*DW-1:0]   cfg_o
);
  logic            rd_en;
  logic            commit;
  logic [AW-1:0]   commit_addr;
  logic [DW-1:0]   commit_data;
  logic [DW-1:0]   rdata;
  logic [LENW-1:0] len;
  logic [CHW-1:0]  sel;

  hostif_access #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) i_access (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode_i),
    .cs_ni        (cs_ni),
    .rd_ni        (rd_ni),
    .wr_ni        (wr_ni),
    .addr_i       (addr_i),
    .data_i       (data_i),
    .rd_en_o      (rd_en),
    .commit_o     (commit),
    .commit_addr_o(commit_addr),
    .commit_data_o(commit_data)
  );

  hostif_regbank #(.NCFG(NCFG), .AW(AW), .LENW(LENW), .CHW(CHW)) i_regbank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit),
    .commit_addr_i(commit_addr),
    .commit_data_i(commit_data),
    .rd_addr_i    (addr_i),
    .status_i     (status_i),
    .rdata_o      (rdata),
    .cfg_o        (cfg_o),
    .len_o        (len),
    .sel_o        (sel)
  );

  hostif_irq #(.NCH(NCH), .CHW(CHW), .LENW(LENW)) i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .new_data_i(new_data_i),
    .sel_i     (sel),
    .len_i     (len),
    .irq_o     (irq_o)
  );

  assign data_oe_o = rd_en;
  assign data_o    = rd_en ? rdata : '0;

  AST_OE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !data_oe_o); // R4
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0)); // R2
endmodule

// File: tb/test_hostif_top.sv
module test_hostif_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [3:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        oe;
  logic [15:0] status = 16'hA5C3;
  logic [3:0]  nd = '0;
  logic        irq;
  logic [63:0] cfg;

  always #2 clk = ~clk;

  hostif_top i_hostif_top (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cs_ni(cs_n), .rd_ni(rd_n),
    .wr_ni(wr_n), .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .status_i(status), .new_data_i(nd), .irq_o(irq), .cfg_o(cfg)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural model state
  logic [15:0] m_cfg [4];
  int          m_len;
  int          m_sel;
  int          m_cnt;
  int          pw_cd = 0;
  int          pw_addr;
  logic [15:0] pw_data;
  string       irq_tag = "R8";

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_read(int a);
    if (a < 4)  return m_cfg[a];
    if (a == 4) return 16'(m_len);
    if (a == 5) return 16'(m_sel);
    if (a == 6) return status;
    return 16'h0;
  endfunction

  // Cycle-by-cycle reference model, compared every clock.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) m_cfg[k] = '0;
      m_len = 1; m_sel = 0; m_cnt = 0; pw_cd = 0;
    end else begin
      if (nd[m_sel])       m_cnt = m_len;
      else if (m_cnt > 0)  m_cnt = m_cnt - 1;
      if (pw_cd == 1) begin
        if (pw_addr < 4)       m_cfg[pw_addr] = pw_data;
        else if (pw_addr == 4) m_len = int'(pw_data[7:0]);
        else if (pw_addr == 5) m_sel = int'(pw_data[1:0]);
      end
      if (pw_cd > 0) pw_cd = pw_cd - 1;
      #1;
      chk(irq_tag, 32'(irq), 32'(m_cnt != 0));
      if (cs_n) chk("R4", 32'(oe), 0);
      else if (mode) chk("R3", 32'(oe), 32'(rd_n));
      else chk("R2", 32'(oe), 32'(!rd_n));
    end
  end

  task automatic wr_split(int a, logic [15:0] d);
    @(negedge clk); addr = 4'(a); din = d; cs_n = 0; wr_n = 0;
    repeat (2) @(negedge clk);
    wr_n = 1; cs_n = 1; pw_addr = a; pw_data = d; pw_cd = 3;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_rw(int a, logic [15:0] d);
    @(negedge clk); addr = 4'(a); din = d; rd_n = 0; cs_n = 0;
    repeat (2) @(negedge clk);
    cs_n = 1; pw_addr = a; pw_data = d; pw_cd = 3;
    @(negedge clk); rd_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_chk(int a, string req);
    @(negedge clk); addr = 4'(a); cs_n = 0; rd_n = mode ? 1'b1 : 1'b0;
    #1;
    chk(req, 32'(oe), 1);
    chk(req, 32'(dout), 32'(m_read(a)));
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  task automatic event_on(int ch);
    @(negedge clk); nd[ch] = 1'b1;
    @(negedge clk); nd[ch] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", 32'(irq), 0);
    chk("R1", 32'(oe), 0);
    for (int a = 0; a < 6; a++) rd_chk(a, "R1");

    // separate-strobe writes
    wr_split(0, 16'h1234);
    wr_split(1, 16'hBEEF);
    wr_split(2, 16'h00FF);
    wr_split(3, 16'h8001);
    for (int a = 0; a < 4; a++) rd_chk(a, "R5");
    chk("R5", cfg[31:16], 32'h0000BEEF);

    // chip enable high blocks read
    @(negedge clk); addr = 0; rd_n = 0; cs_n = 1; #1;
    chk("R4", 32'(oe), 0);
    @(negedge clk); rd_n = 1;

    // map: status read-only, unmapped zero and ignored
    rd_chk(6, "R7");
    wr_split(6, 16'h5555);
    rd_chk(6, "R7");
    wr_split(7, 16'h7777);
    wr_split(15, 16'hFFFF);
    rd_chk(7, "R7");
    rd_chk(15, "R7");
    for (int a = 0; a < 6; a++) rd_chk(a, "R7");
    wr_split(4, 16'hAB05);
    rd_chk(4, "R7");
    wr_split(5, 16'hFFFE);
    rd_chk(5, "R7");

    // direction-line mode
    @(negedge clk); mode = 1;
    wr_rw(1, 16'hCAFE);
    wr_rw(3, 16'h4242);
    rd_chk(1, "R6");
    rd_chk(3, "R3");
    // stray write strobe during a read access in mode 1
    @(negedge clk); addr = 0; din = 16'hDEAD; cs_n = 0; rd_n = 1; wr_n = 0;
    repeat (2) @(negedge clk);
    wr_n = 1; cs_n = 1;
    repeat (5) @(negedge clk);
    rd_chk(0, "R12");
    chk("R12", cfg[15:0], 32'h00001234);

    // interrupt behaviour
    @(negedge clk); mode = 0;
    wr_split(4, 16'd5);
    wr_split(5, 16'd2);
    irq_tag = "R8";
    event_on(2);
    repeat (8) @(negedge clk);
    event_on(1);
    event_on(3);
    repeat (8) @(negedge clk);
    irq_tag = "R9";
    event_on(2);
    repeat (2) @(negedge clk);
    event_on(2);
    repeat (8) @(negedge clk);
    irq_tag = "R10";
    wr_split(4, 16'd0);
    event_on(2);
    repeat (4) @(negedge clk);
    chk("R10", 32'(irq), 0);

    // same-edge collision: length write commit with event
    irq_tag = "R11";
    wr_split(4, 16'd3);
    @(negedge clk); addr = 4; din = 16'd7; cs_n = 0; wr_n = 0;
    repeat (2) @(negedge clk);
    wr_n = 1; cs_n = 1; pw_addr = 4; pw_data = 16'd7; pw_cd = 3;
    repeat (2) @(negedge clk);
    nd[2] = 1;                      // sampled on the commit edge
    @(negedge clk); nd[2] = 0;
    chk("R11", 32'(irq), 1);
    repeat (2) @(negedge clk);
    chk("R11", 32'(irq), 1);
    @(negedge clk);
    chk("R11", 32'(irq), 0);        // old length 3 used
    repeat (4) @(negedge clk);
    // select-change collision
    @(negedge clk); addr = 5; din = 16'd1; cs_n = 0; wr_n = 0;
    repeat (2) @(negedge clk);
    wr_n = 1; cs_n = 1; pw_addr = 5; pw_data = 16'd1; pw_cd = 3;
    repeat (2) @(negedge clk);
    nd[1] = 1;                      // old select is 2: ignored
    @(negedge clk); nd[1] = 0;
    chk("R11", 32'(irq), 0);
    repeat (10) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule